// File: doc/BRIEF.md
# Reloading Up-Counter with PWM and Output Compare

The block is a 12-bit timer that counts up once per enabled tick. When it reaches the all-ones value it signals an overflow and restarts from a programmable reload value. This sets both the period and the resolution of a single output channel. That channel works in one of two modes, chosen by an output-enable control bit:
- As a pulse-width modulator, it drives a pin that turns active at each reload and inactive when the count reaches the duty value.
- As an output compare, it sets a flag and can request an interrupt when the count equals the duty value.

Software programs the block one byte at a time. The 12-bit duty value is written as a high part and then a low part. Writing the high part freezes all matching until the low part is written. At every overflow the duty value is copied into a shadow register, whether or not both halves are complete. Modulation compares the count against this shadow, so a new duty takes effect at the next period boundary. Output compare uses the live duty value, so a new value applies at once. Slow and halted operation are modelled from outside: a tick-enable input that pulses once every 32 clocks, or stays low.

Top module: `arl_pwm_timer`

## Requirements
- R1: After reset the counter, reload value, duty value, shadow, control bits and both flags are 0. The pin is low and no interrupt is requested.
- R2: The counter advances by one on each clock where `tick_en` is 1. It holds its value when `tick_en` is 0.
- R3: On a tick at count 0xFFF the counter loads the reload value and the overflow flag (`stat_o[1]`) is set. For example, with reload 0xFFD the sequence is FFD, FFE, FFF, FFD.
- R4: On every overflow the shadow register takes the live duty value, even if the high part is new and the low part is not yet written.
- R5: Writing the duty high part (address 2) locks compare and modulation. While locked, no compare flag is set and the pin is not cleared. Writing the low part (address 3) removes the lock.
- R6: With control bit 0 (output enable) at 0, a count equal to the live duty value sets the compare flag (`stat_o[0]`) one clock later, without waiting for an overflow. The pin rests at its inactive level, which equals the polarity bit.
- R7: A duty value of 0 never sets the compare flag.
- R8: With output enable at 1, an internal level is set at each overflow and cleared one clock after the count equals the shadow value. The pin equals this level XOR control bit 1 (polarity).
- R9: Asserting `rd_en` for one clock clears both flags at that edge. A flag event at the same edge wins over the clear.
- R10: `irq_o` is 1 when (compare flag AND control bit 2) OR (overflow flag AND control bit 3).
- R11: The write map is: address 0 holds the reload bits 7:0, address 1 holds the reload bits 11:8 from data bits 3:0, address 2 holds the duty high part, address 3 holds the duty low part, and address 4 holds the control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counting enable (divided or stopped clock) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Status read strobe, clears flags |
| stat_o | output | 2 | {overflow flag, compare flag} |
| cnt_o | output | 12 | Current count |
| pwm_o | output | 1 | Modulated output pin |
| irq_o | output | 1 | Interrupt request |

## Verification
Internal faults show up at the ports in one of three ways:
- A corrupted count or reload register appears on `cnt_o` at the next tick. A missing reload makes the count step to 0 instead of the reload value.
- A wrong shadow copy or a lock that never clears appears on `pwm_o` within one period, as the pin falling one count too early or never falling. The split-write scenario is built so that the live and shadow duty values differ by exactly one count.
- A lock that is released too early, or a stuck flag, appears on `stat_o` and `irq_o` one clock after the count passes the duty value.

// File: rtl/arl_pwm_timer.sv
module arl_pwm_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  output logic [1:0]    stat_o,
  output logic [CW-1:0] cnt_o,
  output logic          pwm_o,
  output logic          irq_o
);
  localparam int HW = CW - 8;
  localparam logic [CW-1:0] TOP = '1;

  logic [CW-1:0] cnt_q, reload_q, duty_q, shadow_q;
  logic lock_q, oe_q, pol_q, cie_q, oie_q, cmpf_q, ovff_q, lvl_q;

  wire wrap     = tick_en && (cnt_q == TOP);
  wire live_hit = !lock_q && !oe_q && (duty_q != '0) && (cnt_q == duty_q);
  wire pwm_hit  = !lock_q && oe_q && (cnt_q == shadow_q);
  wire wr_rlo   = wr_en && (wr_addr == 3'd0);
  wire wr_rhi   = wr_en && (wr_addr == 3'd1);
  wire wr_dhi   = wr_en && (wr_addr == 3'd2);
  wire wr_dlo   = wr_en && (wr_addr == 3'd3);
  wire wr_ctl   = wr_en && (wr_addr == 3'd4);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (wrap) cnt_q <= reload_q;
    else if (tick_en) cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reload_q <= '0;
    else if (wr_rlo) reload_q[7:0] <= wr_data;
    else if (wr_rhi) reload_q[CW-1:8] <= wr_data[HW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_q <= '0;
      lock_q <= 1'b0;
    end else if (wr_dhi) begin
      duty_q[CW-1:8] <= wr_data[HW-1:0];
      lock_q <= 1'b1;
    end else if (wr_dlo) begin
      duty_q[7:0] <= wr_data;
      lock_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) shadow_q <= '0;
    else if (wrap) shadow_q <= duty_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) {oie_q, cie_q, pol_q, oe_q} <= '0;
    else if (wr_ctl) {oie_q, cie_q, pol_q, oe_q} <= wr_data[3:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpf_q <= 1'b0;
      ovff_q <= 1'b0;
    end else begin
      cmpf_q <= live_hit | (cmpf_q & ~rd_en);
      ovff_q <= wrap | (ovff_q & ~rd_en);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else if (wrap) lvl_q <= 1'b1;
    else if (pwm_hit) lvl_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign stat_o = {ovff_q, cmpf_q};
  assign pwm_o  = (oe_q & lvl_q) ^ pol_q;
  assign irq_o  = (cmpf_q & cie_q) | (ovff_q & oie_q);
endmodule

module arl_pwm_timer_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] reload,
  input logic [CW-1:0] duty,
  input logic [CW-1:0] shadow,
  input logic          lock,
  input logic          oe,
  input logic          pol,
  input logic          cmpf,
  input logic          pwm
);
  localparam logic [CW-1:0] TOP = '1;

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && cnt != TOP) |=> cnt == CW'($past(cnt) + 1'b1));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt));
  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && cnt == TOP) |=> cnt == $past(reload));
  assert_shadow_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && cnt == TOP) |=> shadow == $past(duty));
  assert_locked_no_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> !$rose(cmpf));
  assert_pin_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> pwm == pol);
  assert_zero_duty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |=> !$rose(cmpf));
endmodule

bind arl_pwm_timer arl_pwm_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt(cnt_q), .reload(reload_q),
  .duty(duty_q), .shadow(shadow_q), .lock(lock_q), .oe(oe_q), .pol(pol_q),
  .cmpf(cmpf_q), .pwm(pwm_o)
);

// File: tb/arl_pwm_timer_tb.sv
module arl_pwm_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] stat_o;
  logic [11:0] cnt_o;
  logic pwm_o, irq_o;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  arl_pwm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .stat_o(stat_o), .cnt_o(cnt_o),
    .pwm_o(pwm_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(output logic [1:0] s);
    @(negedge clk); rd_en = 1'b1; #1 s = stat_o;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic run_until(input logic [11:0] v);
    @(negedge clk); tick_en = 1'b1;
    forever begin
      @(negedge clk);
      if (cnt_o == v) break;
    end
    tick_en = 1'b0;
  endtask

  task automatic pwm_seq(input string tag, input logic [3:0] exp);
    tick_en = 1'b1;
    chk({tag, " pin@FFD"}, pwm_o, exp[3]);
    @(negedge clk); chk({tag, " pin@FFE"}, pwm_o, exp[2]);
    @(negedge clk); chk({tag, " pin@FFF"}, pwm_o, exp[1]);
    @(negedge clk); chk({tag, " pin@FFD again"}, pwm_o, exp[0]);
    tick_en = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cnt", cnt_o, 0);
    chk("R1 stat", stat_o, 0);
    chk("R1 pin", pwm_o, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_count();
    wr(3'd0, 8'hFD); wr(3'd1, 8'h0F);
    run_until(12'hFFF);
    chk("R7 zero duty no flag", stat_o[0], 0);
    chk("R3 no ovf before wrap", stat_o[1], 0);
    tick_en = 1'b1;
    @(negedge clk); chk("R3 wrap to reload", cnt_o, 12'hFFD);
    chk("R3 ovf flag", stat_o[1], 1);
    @(negedge clk); chk("R2 step", cnt_o, 12'hFFE);
    @(negedge clk); chk("R2 step", cnt_o, 12'hFFF);
    @(negedge clk); chk("R3 second wrap", cnt_o, 12'hFFD);
    tick_en = 1'b0;
  endtask

  task automatic t_stall();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); chk("R2 hold", cnt_o, 12'hFFD);
    end
  endtask

  task automatic t_oc();
    logic [1:0] s;
    wr(3'd4, 8'h04); wr(3'd2, 8'h0F); wr(3'd3, 8'hFE);
    rd(s);
    chk("R9 cleared", stat_o, 0);
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    chk("R6 at duty", cnt_o, 12'hFFE);
    @(negedge clk);
    chk("R6 immediate compare flag", stat_o[0], 1);
    chk("R10 cmp irq", irq_o, 1);
    chk("R6 pin idle", pwm_o, 0);
  endtask

  task automatic t_clear();
    logic [1:0] s;
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    rd(s);
    chk("R9 read shows flag", s[0], 1);
    chk("R9 flag cleared", stat_o[0], 0);
    chk("R10 irq dropped", irq_o, 0);
  endtask

  task automatic t_lock();
    logic [1:0] s;
    run_until(12'hFFD);
    rd(s);
    wr(3'd2, 8'h0F);
    run_until(12'hFFF);
    chk("R5 locked no flag", stat_o[0], 0);
    wr(3'd3, 8'hFE);
    run_until(12'hFFE);
    @(negedge clk);
    chk("R5 unlocked flag", stat_o[0], 1);
  endtask

  task automatic t_pwm();
    wr(3'd4, 8'h01);
    run_until(12'hFFD);
    pwm_seq("R8 active high", 4'b1101);
    wr(3'd4, 8'h03);
    pwm_seq("R8 inverted", 4'b0010);
    wr(3'd4, 8'h01);
  endtask

  task automatic t_half();
    wr(3'd0, 8'hFC); wr(3'd1, 8'h0E);
    wr(3'd2, 8'h0E);
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); chk("R8 pin@FFE", pwm_o, 1);
    @(negedge clk); chk("R5 locked pin stays", pwm_o, 1);
    @(negedge clk); tick_en = 1'b0;
    chk("R3 new reload", cnt_o, 12'hEFC);
    wr(3'd3, 8'hFD);
    tick_en = 1'b1;
    chk("R8 pin@EFC", pwm_o, 1);
    @(negedge clk); chk("R4 pin@EFD", pwm_o, 1);
    @(negedge clk); chk("R4 shadow kept old low byte", pwm_o, 1);
    @(negedge clk); chk("R4 pin cleared after EFE", pwm_o, 0);
    tick_en = 1'b0;
  endtask

  task automatic t_irq();
    logic [1:0] s;
    wr(3'd4, 8'h00);
    run_until(12'hF00);
    rd(s);
    run_until(12'hEFC);
    chk("R3 ovf only", stat_o, 2'b10);
    chk("R10 masked", irq_o, 0);
    wr(3'd4, 8'h08);
    chk("R10 ovf irq", irq_o, 1);
    rd(s);
    chk("R9 read value", s, 2'b10);
    chk("R10 irq after read", irq_o, 0);
    wr(3'd4, 8'h04);
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    @(negedge clk);
    chk("R6 flag at EFD", stat_o[0], 1);
    chk("R10 cmp irq", irq_o, 1);
    rd(s);
    chk("R9 set wins over clear", stat_o[0], 1);
  endtask

  task automatic t_zero();
    logic [1:0] s;
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    rd(s);
    run_until(12'h000);
    @(negedge clk); @(negedge clk);
    chk("R7 zero duty at count 0", stat_o[0], 0);
    chk("R11 reload map to 0", cnt_o, 0);
  endtask

  initial begin
    t_reset();
    t_count();
    t_stall();
    t_oc();
    t_clear();
    t_lock();
    t_pwm();
    t_half();
    t_irq();
    t_zero();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule